// File: doc/BRIEF.md
# OFDM Packet Timing Sequencer

This block follows an OFDM packet in time once a packet-detect event has arrived. It captures the timing fields of a 32-bit configuration word when the detect pulse is accepted. It then counts sample-valid cycles and reports which part of the packet is on the air: a programmable detect-delay period, the short training symbols, the cyclic prefix ahead of the long training symbols, the long symbols themselves, and the payload.

Each section boundary raises a strobe. Two further strobes mark points inside the preamble. The FFT-window start comes a programmable number of samples after the first long symbol begins. The CFO-calculation start comes a programmable number of samples after the cyclic prefix begins. Downstream FFT and frequency-offset logic use these marks to line up their work. Once a packet has been accepted, the block ignores any further detect pulse until the next reset.

Top module: `ofdm_pkt_timer`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `section` reads 0 (idle), every strobe is low and `samp_idx` is 0.
- R2: A packet is accepted only on a clock edge where `det_pulse`, `smp_en` and idle are all true. After that edge `samp_idx` is 0. A `det_pulse` without `smp_en` changes nothing.
- R3: During a packet, `samp_idx` grows by one on every edge with `smp_en` high and holds on every other edge.
- R4: `samp_idx` saturates at 65535 and does not wrap. When it saturates, the section stays at payload and no strobe fires again.
- R5: The detect delay D is `cfg_word[6:0]`. `section` reads 1 (delay) while `samp_idx` < D. The short section begins at `samp_idx` == D. The relative count rel = `samp_idx` − D.
- R6: The section codes are 2 for short (rel 0..95, six 16-sample symbols), 3 for prefix (rel 96..127), 4 for long (rel 128..255, two 64-sample symbols) and 5 for payload (rel ≥ 256).
- R7: `ss_stb`, `lcp_stb`, `ls_stb` and `pl_stb` are high exactly while rel equals 0, 96, 128 and 256 respectively. That is one sample-valid period each, and at most one of them is high at a time.
- R8: `fft_stb` is high exactly while rel equals 128 + `cfg_word[12:7]`.
- R9: `cfo_stb` is high exactly while rel equals 96 + `cfg_word[20:16]`.
- R10: The timing fields are sampled at acceptance. Later changes to `cfg_word` do not move any boundary of the running packet. Bits [31:21] and [15:13] are not used.
- R11: A `det_pulse` during a packet does not restart or change it. Only `rst` returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample-valid qualifier |
| det_pulse | input | 1 | Packet-detect event |
| cfg_word | input | 32 | Packed timing configuration |
| section | output | 3 | Current section code |
| ss_stb | output | 1 | Short-symbol section start |
| lcp_stb | output | 1 | Long-symbol prefix start |
| ls_stb | output | 1 | Long-symbol section start |
| pl_stb | output | 1 | Payload start |
| fft_stb | output | 1 | FFT window start |
| cfo_stb | output | 1 | CFO calculation start |
| samp_idx | output | 16 | Sample-valid cycles since acceptance |

## Verification
The bench sweeps the detect delay across zero, small and maximum values. It pairs each delay with the extreme and typical FFT offsets and the extreme CFO delays, under gapped and gapless sample-enable patterns. Every output is compared on every cycle.

A zero delay catches a design that lags the short strobe by a cycle. Gapped enables expose strobes that last one clock instead of one sample. A second detect pulse and a scrambled configuration word during the packet catch a design that restarts or re-reads its fields. A run past 65535 samples catches a counter that wraps and fires the short strobe a second time.

// File: rtl/ofdm_pkt_timer_pkg.sv
package ofdm_pkt_timer_pkg;

    localparam int CNT_W     = 16;
    localparam int SHORT_LEN = 16;
    localparam int SHORT_NUM = 6;
    localparam int LCP_LEN   = 32;
    localparam int LONG_LEN  = 64;
    localparam int LONG_NUM  = 2;

    typedef enum logic [2:0] {
        SEC_IDLE    = 3'd0,
        SEC_DELAY   = 3'd1,
        SEC_SHORT   = 3'd2,
        SEC_LCP     = 3'd3,
        SEC_LONG    = 3'd4,
        SEC_PAYLOAD = 3'd5
    } sec_e;

    // timing fields kept from the configuration word
    typedef struct packed {
        logic [4:0] cfo_dly;
        logic [5:0] fft_ofs;
        logic [6:0] det_dly;
    } tcfg_t;

    function automatic tcfg_t unpack_cfg(input logic [31:0] w);
        tcfg_t c;
        c.det_dly = w[6:0];
        c.fft_ofs = w[12:7];
        c.cfo_dly = w[20:16];
        return c;
    endfunction

endpackage

// File: rtl/pkt_timer_count.sv
module pkt_timer_count
    import ofdm_pkt_timer_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_en,
    input  logic          det_pulse,
    input  tcfg_t         cfg_i,
    output logic          active,
    output logic [CW-1:0] pos,
    output tcfg_t         cfg_q
);
    localparam logic [CW-1:0] POS_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos    <= '0;
            cfg_q  <= '0;
        end else if (smp_en) begin
            if (!active && det_pulse) begin
                active <= 1'b1;
                pos    <= '0;
                cfg_q  <= cfg_i;
            end else if (active && pos != POS_MAX) begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && smp_en && pos != POS_MAX) |=> pos == $past(pos) + 1'b1);
    // R4
    sat_chk: assert property (@(posedge clk) disable iff (rst)
        (active && smp_en && pos == POS_MAX) |=> pos == POS_MAX);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> ($stable(pos) && $stable(active)));
    // R10
    cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(cfg_q));
endmodule

// File: rtl/pkt_timer_decode.sv
module pkt_timer_decode
    import ofdm_pkt_timer_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int SLEN   = SHORT_LEN,
    parameter int SNUM   = SHORT_NUM,
    parameter int CPLEN  = LCP_LEN,
    parameter int LLEN   = LONG_LEN,
    parameter int LNUM   = LONG_NUM
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [CW-1:0] pos,
    input  tcfg_t         cfg_q,
    output sec_e          section,
    output logic [3:0]    bnd_stb,
    output logic          fft_stb,
    output logic          cfo_stb
);
    localparam int MARK_LCP = SNUM * SLEN;
    localparam int MARK_LS  = MARK_LCP + CPLEN;
    localparam int MARK_PL  = MARK_LS + LNUM * LLEN;
    localparam int MARKS [4] = '{0, MARK_LCP, MARK_LS, MARK_PL};

    logic [CW-1:0] dly;
    logic [CW-1:0] rel;
    logic          started;

    assign dly     = CW'(cfg_q.det_dly);
    assign started = active && (pos >= dly);
    assign rel     = pos - dly;

    for (genvar g = 0; g < 4; g++) begin : g_bnd
        assign bnd_stb[g] = started && (rel == CW'(MARKS[g]));
    end

    assign fft_stb = started && (rel == CW'(MARK_LS)  + CW'(cfg_q.fft_ofs));
    assign cfo_stb = started && (rel == CW'(MARK_LCP) + CW'(cfg_q.cfo_dly));

    always_comb begin
        if (!active)                   section = SEC_IDLE;
        else if (!started)             section = SEC_DELAY;
        else if (rel < CW'(MARK_LCP))  section = SEC_SHORT;
        else if (rel < CW'(MARK_LS))   section = SEC_LCP;
        else if (rel < CW'(MARK_PL))   section = SEC_LONG;
        else                           section = SEC_PAYLOAD;
    end

    // R7
    bnd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bnd_stb));
    // R8
    fft_in_long_chk: assert property (@(posedge clk) disable iff (rst)
        fft_stb |-> section == SEC_LONG);
    // R9
    cfo_in_lcp_chk: assert property (@(posedge clk) disable iff (rst)
        cfo_stb |-> section == SEC_LCP);
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (section == SEC_IDLE) |-> (bnd_stb == 4'b0 && !fft_stb && !cfo_stb));
endmodule

// File: rtl/ofdm_pkt_timer.sv
module ofdm_pkt_timer
    import ofdm_pkt_timer_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_en,
    input  logic          det_pulse,
    input  logic [31:0]   cfg_word,
    output logic [2:0]    section,
    output logic          ss_stb,
    output logic          lcp_stb,
    output logic          ls_stb,
    output logic          pl_stb,
    output logic          fft_stb,
    output logic          cfo_stb,
    output logic [CW-1:0] samp_idx
);
    logic          active;
    logic [CW-1:0] pos;
    tcfg_t         cfg_q;
    sec_e          sec;
    logic [3:0]    bnd;
    logic          unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_word[31:21], cfg_word[15:13]};

    pkt_timer_count #(.CW(CW)) u_count (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .det_pulse (det_pulse),
        .cfg_i     (unpack_cfg(cfg_word)),
        .active    (active),
        .pos       (pos),
        .cfg_q     (cfg_q)
    );

    pkt_timer_decode #(.CW(CW)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .pos     (pos),
        .cfg_q   (cfg_q),
        .section (sec),
        .bnd_stb (bnd),
        .fft_stb (fft_stb),
        .cfo_stb (cfo_stb)
    );

    assign section  = sec;
    assign ss_stb   = bnd[0];
    assign lcp_stb  = bnd[1];
    assign ls_stb   = bnd[2];
    assign pl_stb   = bnd[3];
    assign samp_idx = pos;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (section == 3'd0 && samp_idx == '0));
endmodule

// File: tb/ofdm_pkt_timer_tb.sv
`timescale 1ns/1ps
module ofdm_pkt_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b0;
    logic        det_pulse = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [2:0]  section;
    logic        ss_stb, lcp_stb, ls_stb, pl_stb, fft_stb, cfo_stb;
    logic [15:0] samp_idx;

    always #10 clk = ~clk;

    ofdm_pkt_timer u_dut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .det_pulse(det_pulse),
        .cfg_word(cfg_word), .section(section), .ss_stb(ss_stb),
        .lcp_stb(lcp_stb), .ls_stb(ls_stb), .pl_stb(pl_stb),
        .fft_stb(fft_stb), .cfo_stb(cfo_stb), .samp_idx(samp_idx)
    );

    int n_run = 0;
    int n_fail = 0;

    // independent model state
    bit m_act;
    int m_pos, m_d, m_ofs, m_cfo;

    task automatic check(input string tag);
        int rel;
        int e_sec;
        logic [5:0] e_stb, a_stb;
        rel = m_pos - m_d;
        e_stb = '0;
        if (!m_act) e_sec = 0;
        else if (m_pos < m_d) e_sec = 1;
        else begin
            if (rel < 96) e_sec = 2;
            else if (rel < 128) e_sec = 3;
            else if (rel < 256) e_sec = 4;
            else e_sec = 5;
            e_stb = {rel == 96 + m_cfo, rel == 128 + m_ofs,
                     rel == 256, rel == 128, rel == 96, rel == 0};
        end
        a_stb = {cfo_stb, fft_stb, pl_stb, ls_stb, lcp_stb, ss_stb};
        n_run++;
        if (section !== 3'(e_sec) || a_stb !== e_stb || samp_idx !== 16'(m_act ? m_pos : 0)) begin
            n_fail++;
            $display("FAIL %s: got sec=%0d stb=%b idx=%0d, exp sec=%0d stb=%b idx=%0d",
                     tag, section, a_stb, samp_idx, e_sec, e_stb, m_act ? m_pos : 0);
        end
    endtask

    task automatic tick(input bit en, input bit det, input logic [31:0] cw, input string tag);
        smp_en = en; det_pulse = det; cfg_word = cw;
        @(posedge clk);
        if (rst) begin
            m_act = 0; m_pos = 0; m_d = 0; m_ofs = 0; m_cfo = 0;
        end else if (en) begin
            if (!m_act && det) begin
                m_act = 1; m_pos = 0;
                m_d = int'(cw[6:0]); m_ofs = int'(cw[12:7]); m_cfo = int'(cw[20:16]);
            end else if (m_act && m_pos != 65535) m_pos++;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1, 1, 32'h0000_0005, "R1 reset");
        tick(0, 0, 32'h0, "R1 reset");
        rst = 1'b0;
        tick(0, 0, 32'h0, "R1 after reset");
    endtask

    initial begin
        #3_800_000;
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int dv [3] = '{0, 3, 127};
        int ov [3] = '{0, 10, 63};
        int cv [2] = '{0, 31};
        int idx = 0;
        @(negedge clk);
        do_reset();
        // R2: detect without sample enable is ignored
        tick(0, 1, 32'h0000_0002, "R2 det without smp_en");
        tick(0, 0, 32'h0, "R2 still idle");

        foreach (dv[i]) foreach (ov[j]) foreach (cv[k]) begin
            logic [31:0] cw;
            int p;
            cw = 32'hA5E0_0000 | 32'(dv[i]) | (32'(ov[j]) << 7) | (32'(cv[k]) << 16);
            p = idx % 3;
            idx++;
            do_reset();
            tick(1, 1, cw, "R2 accept");
            for (int c = 0; m_pos < dv[i] + 262; c++) begin
                bit en;
                en = (p == 0) ? 1'b1 : (p == 1) ? (c % 2 == 0) : (c % 3 != 2);
                // R10/R11: scrambled config and extra detect mid-packet
                tick(en, (c == 40 || c == 200), ~cw,
                     "R3 R5 R6 R7 R8 R9 R10 R11");
            end
        end

        // R4: saturation after long run
        do_reset();
        tick(1, 1, 32'h0000_0000, "R2 accept");
        for (int c = 0; c < 65545; c++)
            tick(1, (c % 1000 == 0), 32'h0000_0040, "R4 R11 saturation");
        if (samp_idx !== 16'hFFFF) begin
            n_fail++;
            $display("FAIL R4: got idx=%0d, exp 65535", samp_idx);
        end
        n_run++;
        tick(0, 1, 32'h0, "R4 hold");
        do_reset();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule